// File: doc/BRIEF.md
# Retirement Trap and Debug Annotator

This block sits beside the retire stage of a simple in-order core and turns each retiring instruction into a trace record. For every retire strobe it emits, one cycle later, a valid pulse, a running 64-bit sequence number, a trap record, a handler-entry record, a debug-entry cause and a debug-mode flag. Program counter, register, CSR and memory reporting are handled elsewhere.

Traps, interrupts and debug entry are treated as happening between instructions. The instruction that faults carries the trap record. The next instruction to retire, which is the first instruction of the handler, carries the entry cause. Entry causes from synchronous traps, taken interrupts, external debug requests and single-step events are held in two pending slots. One slot is for handler entry and one is for debug entry. Each slot is emptied when its contents are reported.

A trace consumer uses the valid pulse to qualify every other output. It uses the sequence number to detect gaps, and the two entry records to tie each handler's first instruction back to the event that started the handler.

Top module: `rtx_annotator`

## Requirements
- R1: While reset is held and in the first cycle after it, `o_vld` is 0. The first report after reset carries `o_order` = 0, and nothing is pending.
- R2: A retire strobe in cycle N gives `o_vld` = 1 in cycle N+1 only. Each report carries an `o_order` one higher than the report before it.
- R3: Trap record layout:
  - bit 0 is trap, bit 1 is exception, bit 2 is debug.
  - bits 8:3 hold the exception code and bits 13:12 the cause type. Both are zero unless the exception bit is set.
  - bits 11:9 hold the debug cause.
  - bit 14 is the vectored-pointer flag, set only together with the exception bit.
  - Bit 0 is the OR of bits 1 and 2. A retire with no trap input reports an all-zero record.
- R4: A synchronous debug trap (ebreak to debug, cause 1; trigger match, cause 2) sets the debug bit and places its cause in bits 11:9. When an exception is raised in the same retire, the debug trap wins: the exception bit and the exception fields read 0.
- R5: A single-stepped retire sets the debug bit, with cause 4 in bits 11:9 unless a debug trap is also present. If it also raises an exception, the exception bit and the debug bit are both set.
- R6: After an exception, the next report's handler-entry record has bit 0 = 1, bit 1 = 1, bit 2 = 0, and the exception code zero-extended in bits 13:3. The report after that has a handler-entry record of 0.
- R7: After an interrupt is taken, the next report's handler-entry record has bit 0 = 1, bit 1 = 0, bit 2 = 1, and the 11-bit interrupt cause in bits 13:3.
- R8: `o_dbg_cause` is 0 except on the first report after debug entry, where it is 1 (ebreak), 2 (trigger), 3 (external request) or 4 (single step). Debug entry alone leaves the handler-entry record at 0.
- R9: An ebreak debug trap taken while already in debug mode is still reported with debug cause 1, on both the trap record and the following report.
- R10: An exception on a single-stepped retire makes the next report carry both the exception handler-entry record and debug cause 4.
- R11: `o_dbg_mode` equals the retire's debug-mode input.
- R12: An asynchronous event whose slot is already pending is dropped. A slot being filled by the same cycle's retire also counts as pending, so a synchronous cause wins. An asynchronous event in the same cycle as a retire is reported on the following retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rt_vld | input | 1 | Instruction retires this cycle |
| rt_in_dbg | input | 1 | Retiring instruction executed in debug mode |
| rt_exc | input | 1 | Retiring instruction raises an exception |
| rt_exc_code | input | 6 | Exception code |
| rt_exc_ctype | input | 2 | Cause type that separates faults sharing a code |
| rt_vecptr | input | 1 | The faulting fetch was a vectored-interrupt pointer |
| rt_dbg_trap | input | 1 | Retiring instruction enters debug synchronously |
| rt_dbg_cause | input | 3 | Cause of that synchronous debug entry (1 or 2) |
| rt_step | input | 1 | Retiring instruction was single-stepped |
| as_irq | input | 1 | Interrupt taken this cycle |
| as_irq_cause | input | 11 | Cause of the taken interrupt |
| as_dbg_req | input | 1 | External debug request taken this cycle |
| o_vld | output | 1 | Report valid |
| o_order | output | ORDER_W | Report sequence number |
| o_trap | output | 15 | Trap record |
| o_entry | output | 14 | Handler-entry record |
| o_dbg_cause | output | 3 | Debug-entry cause |
| o_dbg_mode | output | 1 | Report's instruction ran in debug mode |

## Verification
The hardest situations to reach are the collisions between slots:
- An asynchronous event arrives while its slot already holds a cause.
- An asynchronous event arrives in the same cycle as a retire that refills the slot.
- An exception and a single step land on one retire, so both entry causes must appear on the next report.

Directed sequences place each of these deliberately, for example an exception retire followed by an interrupt strobe before the next retire. A long stretch of random strobes, with sparse retires and dense asynchronous events, then drives the slots through many back-to-back fills. A behavioural model checks every cycle of it.

// File: rtl/rtx_pkg.sv
// Package: shared record layouts and cause codes for the retirement annotator.
// Assumes records are consumed as flat vectors with bit 0 as the flag bit.
package rtx_pkg;

    localparam int EXC_W    = 6;
    localparam int CTYPE_W  = 2;
    localparam int DCAUSE_W = 3;
    localparam int ICAUSE_W = 11;

    typedef enum logic [DCAUSE_W-1:0] {
        DBG_NONE    = 3'd0,
        DBG_EBREAK  = 3'd1,
        DBG_TRIGGER = 3'd2,
        DBG_EXTREQ  = 3'd3,
        DBG_STEP    = 3'd4
    } dbg_cause_e;

    typedef struct packed {
        logic                vecptr;
        logic [CTYPE_W-1:0]  ctype;
        logic [DCAUSE_W-1:0] dcause;
        logic [EXC_W-1:0]    ecode;
        logic                debug;
        logic                exception;
        logic                trap;
    } trap_rec_t;

    typedef struct packed {
        logic [ICAUSE_W-1:0] cause;
        logic                interrupt;
        logic                exception;
        logic                intr;
    } entry_rec_t;

    localparam int TRAP_W  = $bits(trap_rec_t);
    localparam int ENTRY_W = $bits(entry_rec_t);
    // Pending handler-entry payload: cause plus the two kind bits.
    localparam int ESLOT_W = ICAUSE_W + 2;

endpackage

// File: rtl/rtx_trap_enc.sv
// Trap encoder: builds the trap record of the retiring instruction.
// Assumes the debug-trap cause input is valid only when rt_dbg_trap is set.
// A synchronous debug trap takes precedence over a same-retire exception.
module rtx_trap_enc
    import rtx_pkg::*;
(
    input  logic                rt_exc,
    input  logic [EXC_W-1:0]    rt_exc_code,
    input  logic [CTYPE_W-1:0]  rt_exc_ctype,
    input  logic                rt_vecptr,
    input  logic                rt_dbg_trap,
    input  logic [DCAUSE_W-1:0] rt_dbg_cause,
    input  logic                rt_step,
    output trap_rec_t           rec,
    output logic                exc_eff,
    output logic [DCAUSE_W-1:0] dbg_eff
);

    // Decide which synchronous effects survive the precedence rules.
    always_comb begin
        exc_eff = rt_exc & ~rt_dbg_trap;
        if (rt_dbg_trap)
            dbg_eff = rt_dbg_cause;
        else if (rt_step)
            dbg_eff = DBG_STEP;
        else
            dbg_eff = DBG_NONE;
    end

    // Pack the record, zeroing fields that do not apply.
    always_comb begin
        rec           = '0;
        rec.exception = exc_eff;
        rec.debug     = rt_dbg_trap | rt_step;
        rec.trap      = exc_eff | rt_dbg_trap | rt_step;
        rec.dcause    = dbg_eff;
        if (exc_eff) begin
            rec.ecode  = rt_exc_code;
            rec.ctype  = rt_exc_ctype;
            rec.vecptr = rt_vecptr;
        end
    end

endmodule

// File: rtl/rtx_pend_slot.sv
// Pending slot: holds one entry cause until the next retire reports it.
// Assumes sync_set is only raised together with clr (same retire).
// Priority: synchronous fill, then asynchronous fill into an empty slot
// (empty meaning unoccupied or being cleared this cycle), then clear.
module rtx_pend_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sync_set,
    input  logic [W-1:0] sync_val,
    input  logic         async_set,
    input  logic [W-1:0] async_val,
    output logic         pend,
    output logic [W-1:0] val
);

    logic slot_free;

    // The slot accepts an asynchronous cause only when nothing stays in it.
    always_comb slot_free = clr | ~pend;

    // Update the occupancy flag and payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            val  <= '0;
        end else if (sync_set) begin
            pend <= 1'b1;
            val  <= sync_val;
        end else if (async_set && slot_free) begin
            pend <= 1'b1;
            val  <= async_val;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/rtx_order_ctr.sv
// Order counter: sequence number handed to each report, starting at zero.
// Assumes one increment per retire strobe; wraps at 2**W.
module rtx_order_ctr #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Advance once per report.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rtx_annotator.sv
// Retirement trap and debug annotator top level.
// Registers one report per retire strobe. The faulting instruction carries its
// trap record; entry causes are parked in two pending slots and attached to
// the next retire. Assumes at most one retire per cycle. Outputs other than
// o_vld hold their last value when o_vld is low.
module rtx_annotator
    import rtx_pkg::*;
#(
    parameter int ORDER_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rt_vld,
    input  logic                rt_in_dbg,
    input  logic                rt_exc,
    input  logic [EXC_W-1:0]    rt_exc_code,
    input  logic [CTYPE_W-1:0]  rt_exc_ctype,
    input  logic                rt_vecptr,
    input  logic                rt_dbg_trap,
    input  logic [DCAUSE_W-1:0] rt_dbg_cause,
    input  logic                rt_step,
    input  logic                as_irq,
    input  logic [ICAUSE_W-1:0] as_irq_cause,
    input  logic                as_dbg_req,
    output logic                o_vld,
    output logic [ORDER_W-1:0]  o_order,
    output logic [TRAP_W-1:0]   o_trap,
    output logic [ENTRY_W-1:0]  o_entry,
    output logic [DCAUSE_W-1:0] o_dbg_cause,
    output logic                o_dbg_mode
);

    trap_rec_t           trap_now;
    logic                exc_eff;
    logic [DCAUSE_W-1:0] dbg_eff;
    logic                e_pend, d_pend;
    logic [ESLOT_W-1:0]  e_val, e_sync_val, e_async_val;
    logic [DCAUSE_W-1:0] d_val;
    logic [ORDER_W-1:0]  seq;
    entry_rec_t          entry_now;

    rtx_trap_enc u_enc (
        .rt_exc      (rt_exc),
        .rt_exc_code (rt_exc_code),
        .rt_exc_ctype(rt_exc_ctype),
        .rt_vecptr   (rt_vecptr),
        .rt_dbg_trap (rt_dbg_trap),
        .rt_dbg_cause(rt_dbg_cause),
        .rt_step     (rt_step),
        .rec         (trap_now),
        .exc_eff     (exc_eff),
        .dbg_eff     (dbg_eff)
    );

    // Form handler-entry payloads: {cause, interrupt, exception}.
    always_comb begin
        e_sync_val  = {{(ICAUSE_W-EXC_W){1'b0}}, rt_exc_code, 1'b0, 1'b1};
        e_async_val = {as_irq_cause, 1'b1, 1'b0};
    end

    rtx_pend_slot #(.W(ESLOT_W)) u_entry_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rt_vld),
        .sync_set (rt_vld & exc_eff),
        .sync_val (e_sync_val),
        .async_set(as_irq),
        .async_val(e_async_val),
        .pend     (e_pend),
        .val      (e_val)
    );

    rtx_pend_slot #(.W(DCAUSE_W)) u_dbg_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rt_vld),
        .sync_set (rt_vld & (dbg_eff != DBG_NONE)),
        .sync_val (dbg_eff),
        .async_set(as_dbg_req),
        .async_val(DBG_EXTREQ),
        .pend     (d_pend),
        .val      (d_val)
    );

    rtx_order_ctr #(.W(ORDER_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (rt_vld),
        .cnt  (seq)
    );

    // Expand the pending handler-entry payload into the reported record.
    always_comb begin
        entry_now = '0;
        if (e_pend) begin
            entry_now.intr      = 1'b1;
            entry_now.exception = e_val[0];
            entry_now.interrupt = e_val[1];
            entry_now.cause     = e_val[ESLOT_W-1:2];
        end
    end

    // Report valid pulse, one cycle after each retire.
    always_ff @(posedge clk) begin
        if (!rst_n)
            o_vld <= 1'b0;
        else
            o_vld <= rt_vld;
    end

    // Capture report payload on each retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_order     <= '0;
            o_trap      <= '0;
            o_entry     <= '0;
            o_dbg_cause <= '0;
            o_dbg_mode  <= 1'b0;
        end else if (rt_vld) begin
            o_order     <= seq;
            o_trap      <= trap_now;
            o_entry     <= entry_now;
            o_dbg_cause <= d_pend ? d_val : DBG_NONE;
            o_dbg_mode  <= rt_in_dbg;
        end
    end

endmodule

// File: rtl/rtx_annotator_chk.sv
// Checker for rtx_annotator: relates report outputs to the retire strobe
// and to earlier reports. Attached by bind below.
module rtx_annotator_chk #(
    parameter int ORDER_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rt_vld,
    input logic               o_vld,
    input logic [ORDER_W-1:0] o_order,
    input logic [14:0]        o_trap,
    input logic [13:0]        o_entry,
    input logic [2:0]         o_dbg_cause
);

    logic               past_ok;
    logic               seen;
    logic [ORDER_W-1:0] last_order;

    // Mark that one clock has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Remember the previous report's sequence number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen       <= 1'b0;
            last_order <= '0;
        end else if (o_vld) begin
            seen       <= 1'b1;
            last_order <= o_order;
        end
    end

    a_r2_vld_follows_retire: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (o_vld == $past(rt_vld)));

    a_r2_order_step: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && seen) |-> (o_order == last_order + 1'b1));

    a_r1_first_order_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && !seen) |-> (o_order == '0));

    a_r3_trap_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (o_trap[0] == (o_trap[1] | o_trap[2])));

    a_r3_exc_fields_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && !o_trap[1]) |-> (o_trap[8:3] == '0 && o_trap[13:12] == '0 && !o_trap[14]));

    a_r6_entry_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_entry[0]) |-> ($countones(o_entry[2:1]) == 1));

    a_r8_entry_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && !o_entry[0]) |-> (o_entry == '0));

    a_r8_dbg_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (o_dbg_cause <= 3'd4));

endmodule

bind rtx_annotator rtx_annotator_chk #(.ORDER_W(ORDER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rt_vld     (rt_vld),
    .o_vld      (o_vld),
    .o_order    (o_order),
    .o_trap     (o_trap),
    .o_entry    (o_entry),
    .o_dbg_cause(o_dbg_cause)
);

// File: tb/sim_rtx_annotator.sv
// Bench for rtx_annotator: behavioural reference model updated at each rising
// edge, outputs compared at every falling edge.
module sim_rtx_annotator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rt_vld = 0, rt_in_dbg = 0, rt_exc = 0, rt_vecptr = 0;
    logic [5:0]  rt_exc_code = 0;
    logic [1:0]  rt_exc_ctype = 0;
    logic        rt_dbg_trap = 0, rt_step = 0;
    logic [2:0]  rt_dbg_cause = 0;
    logic        as_irq = 0, as_dbg_req = 0;
    logic [10:0] as_irq_cause = 0;

    logic        o_vld;
    logic [63:0] o_order;
    logic [14:0] o_trap;
    logic [13:0] o_entry;
    logic [2:0]  o_dbg_cause;
    logic        o_dbg_mode;

    always #2 clk = ~clk;

    rtx_annotator u0 (
        .clk(clk), .rst_n(rst_n), .rt_vld(rt_vld), .rt_in_dbg(rt_in_dbg),
        .rt_exc(rt_exc), .rt_exc_code(rt_exc_code), .rt_exc_ctype(rt_exc_ctype),
        .rt_vecptr(rt_vecptr), .rt_dbg_trap(rt_dbg_trap), .rt_dbg_cause(rt_dbg_cause),
        .rt_step(rt_step), .as_irq(as_irq), .as_irq_cause(as_irq_cause),
        .as_dbg_req(as_dbg_req), .o_vld(o_vld), .o_order(o_order), .o_trap(o_trap),
        .o_entry(o_entry), .o_dbg_cause(o_dbg_cause), .o_dbg_mode(o_dbg_mode)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 0;

    // Reference model state.
    bit          x_vld = 0, x_dm = 0;
    logic [63:0] x_order = 0;
    logic [14:0] x_trap = 0;
    logic [13:0] x_entry = 0;
    logic [2:0]  x_dbg = 0;
    longint      m_cnt = 0;
    bit          m_epend = 0;
    logic [13:0] m_entry = 0;
    int          m_dpend = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            x_vld = 0; m_cnt = 0; m_epend = 0; m_dpend = 0;
        end else if (rt_vld) begin
            bit e, d;
            e = rt_exc && !rt_dbg_trap;
            d = rt_dbg_trap || rt_step;
            x_vld   = 1;
            x_order = m_cnt;
            m_cnt++;
            x_trap  = 15'(e || d) | (15'(e) << 1) | (15'(d) << 2);
            if (e) x_trap = x_trap | (15'(rt_exc_code) << 3) | (15'(rt_exc_ctype) << 12)
                                   | (15'(rt_vecptr) << 14);
            if (rt_dbg_trap) x_trap = x_trap | (15'(rt_dbg_cause) << 9);
            else if (rt_step) x_trap = x_trap | (15'd4 << 9);
            x_entry = m_epend ? m_entry : 14'd0;
            x_dbg   = 3'(m_dpend);
            x_dm    = rt_in_dbg;
            m_epend = 0; m_dpend = 0;
            if (e) begin m_epend = 1; m_entry = 14'h3 | (14'(rt_exc_code) << 3); end
            if (rt_dbg_trap) m_dpend = int'(rt_dbg_cause);
            else if (rt_step) m_dpend = 4;
            if (as_irq && !m_epend) begin
                m_epend = 1; m_entry = 14'h5 | (14'(as_irq_cause) << 3);
            end
            if (as_dbg_req && m_dpend == 0) m_dpend = 3;
        end else begin
            x_vld = 0;
            if (as_irq && !m_epend) begin
                m_epend = 1; m_entry = 14'h5 | (14'(as_irq_cause) << 3);
            end
            if (as_dbg_req && m_dpend == 0) m_dpend = 3;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(o_vld == x_vld, "vld", 64'(o_vld), 64'(x_vld));
            if (x_vld) begin
                chk(o_order == x_order, "order", o_order, x_order);
                chk(o_trap == x_trap, "trap", 64'(o_trap), 64'(x_trap));
                chk(o_entry == x_entry, "entry", 64'(o_entry), 64'(x_entry));
                chk(o_dbg_cause == x_dbg, "dbg_cause", 64'(o_dbg_cause), 64'(x_dbg));
                chk(o_dbg_mode == x_dm, "dbg_mode", 64'(o_dbg_mode), 64'(x_dm));
            end
        end
    end

    task automatic idle();
        rt_vld = 0; rt_in_dbg = 0; rt_exc = 0; rt_exc_code = 0; rt_exc_ctype = 0;
        rt_vecptr = 0; rt_dbg_trap = 0; rt_dbg_cause = 0; rt_step = 0;
        as_irq = 0; as_irq_cause = 0; as_dbg_req = 0;
    endtask

    task automatic step_clk();
        @(negedge clk);
        idle();
    endtask

    task automatic plain_retire(input bit dm);
        rt_vld = 1; rt_in_dbg = dm; step_clk();
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle();
        tag = "R1";
        repeat (3) @(negedge clk);
        chk(o_vld == 0, "vld in reset", 64'(o_vld), 0);
        rst_n = 1;
        step_clk();
        chk(o_vld == 0, "vld after reset", 64'(o_vld), 0);
        plain_retire(0);             // first report: order 0
        tag = "R2"; plain_retire(0); plain_retire(0); step_clk(); plain_retire(0);
        tag = "R11"; plain_retire(1); plain_retire(0); plain_retire(1);
        // R3/R6: exception, then handler first instruction
        tag = "R3"; rt_vld = 1; rt_exc = 1; rt_exc_code = 6'h02; step_clk();
        tag = "R6"; plain_retire(0); plain_retire(0);
        tag = "R3"; rt_vld = 1; rt_exc = 1; rt_exc_code = 6'h05; rt_exc_ctype = 1;
        rt_vecptr = 1; step_clk(); plain_retire(0);
        // R4: debug trap beats exception
        tag = "R4"; rt_vld = 1; rt_exc = 1; rt_exc_code = 6'h03; rt_dbg_trap = 1;
        rt_dbg_cause = 1; step_clk();
        tag = "R8"; plain_retire(1); plain_retire(1);
        tag = "R9"; rt_vld = 1; rt_in_dbg = 1; rt_dbg_trap = 1; rt_dbg_cause = 1; step_clk();
        plain_retire(1);
        tag = "R4"; rt_vld = 1; rt_dbg_trap = 1; rt_dbg_cause = 2; step_clk(); plain_retire(1);
        tag = "R5"; rt_vld = 1; rt_step = 1; step_clk(); plain_retire(1);
        tag = "R10"; rt_vld = 1; rt_step = 1; rt_exc = 1; rt_exc_code = 6'h0B; step_clk();
        plain_retire(1);
        tag = "R7"; as_irq = 1; as_irq_cause = 11'h7FF; step_clk(); step_clk(); plain_retire(0);
        tag = "R8"; as_dbg_req = 1; step_clk(); plain_retire(1);
        // R12: exception pending, interrupt dropped
        tag = "R12"; rt_vld = 1; rt_exc = 1; rt_exc_code = 6'h07; step_clk();
        as_irq = 1; as_irq_cause = 11'h011; step_clk(); plain_retire(0); plain_retire(0);
        // R12: async in same cycle as retire goes to the following retire
        rt_vld = 1; as_dbg_req = 1; as_irq = 1; as_irq_cause = 11'h123; step_clk();
        plain_retire(1); plain_retire(0);
        // R12: sync step wins over same-cycle external request
        rt_vld = 1; rt_step = 1; as_dbg_req = 1; step_clk(); plain_retire(1);
        // R12: random mix
        for (int i = 0; i < 3000; i++) begin
            rt_vld       = ($urandom % 3) == 0;
            rt_in_dbg    = $urandom % 2;
            rt_exc       = ($urandom % 4) == 0;
            rt_exc_code  = 6'($urandom);
            rt_exc_ctype = 2'($urandom);
            rt_vecptr    = $urandom % 2;
            rt_dbg_trap  = ($urandom % 6) == 0;
            rt_dbg_cause = 3'(1 + $urandom % 2);
            rt_step      = ($urandom % 6) == 0;
            as_irq       = ($urandom % 3) == 0;
            as_irq_cause = 11'($urandom);
            as_dbg_req   = ($urandom % 4) == 0;
            step_clk();
        end
        repeat (3) step_clk();
        finish_run();
    end

endmodule